// File: doc/BRIEF.md
# Convergent-Rounding Fixed-Point Multiplier

This block multiplies two signed 16-bit fixed-point samples and returns a product in the same 16-bit format. It is meant to sit inside a FIR filter datapath, where a coefficient and a delayed sample meet at each tap. Every word carries a sign bit, four integer bits and eleven fraction bits. A code therefore stands for the value code/2048, over the range -16.0 to just under +16.0.

The full 32-bit product is kept first. It is then narrowed by discarding its eleven lowest bits with round-half-to-even. Plain truncation would add a negative bias to every sample, and an exact half always rounded up would add a small positive bias. Round-half-to-even avoids both, so the filter output carries no DC offset from the rounding step.

A result that does not fit the 16-bit range is clamped to the nearest extreme code, and an overflow flag marks that output. The stream has no back-pressure. An input valid strobe enters with the operands, and the matching output valid leaves two clock cycles later. A new operand pair can be accepted on every cycle.

Top module: `fxm_conv_mult`

## Requirements
- R1: Operands and result are two's-complement 16-bit codes with 11 fraction bits, so a code c represents c/2048. The full 32-bit product (22 fraction bits) is formed without loss before narrowing.
- R2: When no saturation occurs, the result equals the exact product divided by 2048 and rounded to the nearest integer code, for positive and negative products alike.
- R3: When the discarded part of the product (its low 11 bits, taken as a fraction of one output LSB) is exactly one half, the result is the neighbouring code whose least significant bit is 0.
- R4: A discarded part above one half rounds away from the floor, and a discarded part below one half rounds down to the floor.
- R5: A rounded value above 32767 gives result 0x7FFF, and one below -32768 gives result 0x8000. This applies even when the rounding step itself is what pushes the value out of range.
- R6: The overflow output is 1 in exactly the cycles where a valid result was saturated, and 0 otherwise.
- R7: out_vld is in_vld delayed by exactly two clock cycles, and result and ovf belong to the operands presented with that in_vld.
- R8: While rst is high on a rising clock edge, out_vld, result and ovf are 0 after that edge.
- R9: Operands 0x8000 times 0x8000 (-16.0 x -16.0 = +256.0) give result 0x7FFF with ovf set.
- R10: Valid operand pairs may arrive on consecutive cycles. Each one produces its own result, with no stall or gap.
- R11: In a cycle where out_vld is 0, result and ovf are 0, whatever operands were presented without in_vld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand pair is valid this cycle |
| op_a | input | 16 | First operand, signed Q4.11 |
| op_b | input | 16 | Second operand, signed Q4.11 |
| out_vld | output | 1 | Result is valid this cycle |
| result | output | 16 | Rounded and saturated product, signed Q4.11 |
| ovf | output | 1 | Result was clamped to an extreme code |

## Verification
Every internal state error in this block shows at the ports within two cycles. A mistake in the guard, sticky or kept-LSB logic appears as a result that is off by one code, but only on products whose discarded bits sit near the half point. For that reason, directed tie products with both odd and even kept parts, positive and negative, are mixed with the random pairs. A wrong saturation decision or an out-of-step valid pipeline shows as a wrapped extreme value, a stray ovf, or a result paired with the wrong operands on the very output beat that carries it.

// File: rtl/fxm_pkg.sv
package fxm_pkg;

    // Word format
    localparam int DATA_W = 16;
    localparam int FRAC_W = 11;

    // Derived widths
    localparam int PROD_W = 2 * DATA_W;
    localparam int KEEP_W = PROD_W - FRAC_W;
    localparam int RND_W  = KEEP_W + 1;

    typedef logic signed [DATA_W-1:0] word_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [KEEP_W-1:0] keep_t;
    typedef logic signed [RND_W-1:0]  rnd_t;

    localparam word_t WORD_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam word_t WORD_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    // Register after the multiplier
    typedef struct packed {
        logic  vld;
        prod_t prod;
    } prod_stage_t;

    // Register after round and saturate
    typedef struct packed {
        logic  vld;
        word_t data;
        logic  ovf;
    } res_stage_t;

    // A rounded value fits the output word when all bits from the
    // output sign bit upward agree.
    function automatic logic fits_word(input rnd_t v);
        logic [RND_W-DATA_W:0] top;
        top = v[RND_W-1:DATA_W-1];
        return (top == '0) || (top == '1);
    endfunction

    // Clamp value chosen from the sign of the out-of-range number
    function automatic word_t clamp_word(input logic neg);
        return neg ? WORD_MIN : WORD_MAX;
    endfunction

endpackage

// File: rtl/fxm_mul_stage.sv
module fxm_mul_stage
    import fxm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_vld,
    input  word_t       op_a,
    input  word_t       op_b,
    output prod_stage_t st_out
);

    prod_t full_prod;

    // Full-width signed product; the operands are sign-extended by the
    // 32-bit assignment context.
    always_comb begin
        full_prod = prod_t'(op_a) * prod_t'(op_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_out <= '0;
        end else begin
            st_out.vld  <= in_vld;
            st_out.prod <= in_vld ? full_prod : '0;
        end
    end

endmodule

// File: rtl/fxm_conv_round.sv
module fxm_conv_round
    import fxm_pkg::*;
(
    input  prod_t prod,
    output rnd_t  rounded
);

    keep_t kept;
    logic  guard_bit;
    logic  sticky_bit;
    logic  kept_lsb;
    logic  bump;

    always_comb begin
        kept       = prod[PROD_W-1:FRAC_W];
        kept_lsb   = prod[FRAC_W];
        guard_bit  = prod[FRAC_W-1];
        sticky_bit = |prod[FRAC_W-2:0];
        // Above half: bump. Exactly half: bump only toward an even LSB.
        bump       = guard_bit & (sticky_bit | kept_lsb);
        rounded    = {kept[KEEP_W-1], kept} + rnd_t'({1'b0, bump});
    end

endmodule

// File: rtl/fxm_sat_stage.sv
module fxm_sat_stage
    import fxm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  prod_stage_t st_in,
    input  rnd_t        rounded,
    output res_stage_t  st_out
);

    logic  in_range;
    word_t next_data;

    always_comb begin
        in_range  = fits_word(rounded);
        next_data = in_range ? rounded[DATA_W-1:0]
                             : clamp_word(rounded[RND_W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_out <= '0;
        end else if (st_in.vld) begin
            st_out.vld  <= 1'b1;
            st_out.data <= next_data;
            st_out.ovf  <= ~in_range;
        end else begin
            st_out <= '0;
        end
    end

    // R6: a flagged output is one of the two extreme codes
    a_r6_ovf_extreme: assert property (@(posedge clk) disable iff (rst)
        (st_out.vld && st_out.ovf) |->
            (st_out.data == WORD_MAX || st_out.data == WORD_MIN));

    // R11: idle beats carry zeros
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !st_out.vld |-> (st_out.data == '0 && !st_out.ovf));

    // R5: a non-negative product can never clamp to the negative extreme
    a_r5_pos_no_low_clamp: assert property (@(posedge clk) disable iff (rst)
        (st_in.vld && !st_in.prod[PROD_W-1]) |=>
            (!st_out.ovf || st_out.data == WORD_MAX));

    // R5: a negative product can never clamp to the positive extreme
    a_r5_neg_no_high_clamp: assert property (@(posedge clk) disable iff (rst)
        (st_in.vld && st_in.prod[PROD_W-1]) |=>
            (!st_out.ovf || st_out.data == WORD_MIN));

endmodule

// File: rtl/fxm_conv_mult.sv
module fxm_conv_mult
    import fxm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_vld,
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    output logic        out_vld,
    output logic [15:0] result,
    output logic        ovf
);

    prod_stage_t mul_st;
    rnd_t        rnd_val;
    res_stage_t  res_st;

    fxm_mul_stage u_mul (
        .clk    (clk),
        .rst    (rst),
        .in_vld (in_vld),
        .op_a   (word_t'(op_a)),
        .op_b   (word_t'(op_b)),
        .st_out (mul_st)
    );

    fxm_conv_round u_rnd (
        .prod    (mul_st.prod),
        .rounded (rnd_val)
    );

    fxm_sat_stage u_sat (
        .clk     (clk),
        .rst     (rst),
        .st_in   (mul_st),
        .rounded (rnd_val),
        .st_out  (res_st)
    );

    always_comb begin
        out_vld = res_st.vld;
        result  = res_st.data;
        ovf     = res_st.ovf;
    end

    // Cycles since reset, saturating at the pipeline depth
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    // R7: output valid trails input valid by exactly two cycles
    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2) |-> (out_vld == $past(in_vld, 2)));

    // R9: most negative squared clamps high with the flag
    a_r9_min_squared: assert property (@(posedge clk) disable iff (rst)
        (in_vld && op_a == 16'h8000 && op_b == 16'h8000) |->
            ##2 (out_vld && result == 16'h7FFF && ovf));

    // R2: a zero operand always gives a zero, unflagged result
    a_r2_zero_operand: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (op_a == 16'h0000 || op_b == 16'h0000)) |->
            ##2 (out_vld && result == 16'h0000 && !ovf));

endmodule

// File: tb/sim_fxm_conv_mult.sv
module sim_fxm_conv_mult;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [15:0] op_a;
    logic [15:0] op_b;
    logic        out_vld;
    logic [15:0] result;
    logic        ovf;

    always #4 clk = ~clk;   // 125 MHz

    fxm_conv_mult u0 (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .op_a    (op_a),
        .op_b    (op_b),
        .out_vld (out_vld),
        .result  (result),
        .ovf     (ovf)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Expected values for the two beats in flight
    logic        e_vld  [2];
    logic [15:0] e_data [2];
    logic        e_ovf  [2];
    string       e_tag  [2];

    // Reference: exact product, floor division, explicit remainder test
    function automatic void ref_model(input logic [15:0] a, input logic [15:0] b,
                                      output logic [15:0] d, output logic o,
                                      output string tag);
        longint p, q, r;
        p = longint'($signed(a)) * longint'($signed(b));
        q = p / 2048;
        if (p < 0 && q * 2048 != p) q = q - 1;
        r = p - q * 2048;
        tag = (r == 0) ? "R2" : "R4";
        if (r > 1024) begin
            q = q + 1;
        end else if (r == 1024) begin
            tag = "R3";
            if (q % 2 != 0) q = q + 1;
        end
        if (q > 32767) begin
            d = 16'h7FFF; o = 1'b1; tag = {tag, "/R5"};
        end else if (q < -32768) begin
            d = 16'h8000; o = 1'b1; tag = {tag, "/R5"};
        end else begin
            d = q[15:0]; o = 1'b0;
        end
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: check the beat that left the pipe, then drive a new one
    task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b);
        logic [15:0] d;
        logic        o;
        string       t;
        @(negedge clk);
        if (e_vld[1]) begin
            chk({e_tag[1], " R7 out_vld"}, {31'd0, out_vld}, 32'd1);
            chk({e_tag[1], " R1 result"},  {16'd0, result},  {16'd0, e_data[1]});
            chk({e_tag[1], " R6 ovf"},     {31'd0, ovf},     {31'd0, e_ovf[1]});
        end else begin
            chk("R7 out_vld idle", {31'd0, out_vld}, 32'd0);
            chk("R11 result idle", {16'd0, result},  32'd0);
            chk("R11 ovf idle",    {31'd0, ovf},     32'd0);
        end
        e_vld[1]  = e_vld[0];
        e_data[1] = e_data[0];
        e_ovf[1]  = e_ovf[0];
        e_tag[1]  = e_tag[0];
        ref_model(a, b, d, o, t);
        e_vld[0]  = v;
        e_data[0] = d;
        e_ovf[0]  = o;
        e_tag[0]  = t;
        in_vld = v;
        op_a   = a;
        op_b   = b;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd715));
        e_vld[0] = 1'b0; e_vld[1] = 1'b0;
        rst = 1'b1; in_vld = 1'b1; op_a = 16'h7FFF; op_b = 16'h7FFF;
        repeat (3) @(negedge clk);
        // R8: reset clears outputs even with valid operands presented
        chk("R8 out_vld in reset", {31'd0, out_vld}, 32'd0);
        chk("R8 result in reset",  {16'd0, result},  32'd0);
        chk("R8 ovf in reset",     {31'd0, ovf},     32'd0);
        rst = 1'b0; in_vld = 1'b0;

        // R3: ties, odd and even kept parts, both signs
        step(1'b1, 16'h0001, 16'h0400);   // 0.5 LSB  -> 0
        step(1'b1, 16'h0003, 16'h0400);   // 1.5 LSB  -> 2
        step(1'b1, 16'hFFFF, 16'h0400);   // -0.5 LSB -> 0
        step(1'b1, 16'hFFFD, 16'h0400);   // -1.5 LSB -> -2
        step(1'b1, 16'h0005, 16'h0400);   // 2.5 LSB  -> 2
        // R4: just above and below half
        step(1'b1, 16'h0001, 16'h0401);
        step(1'b1, 16'h0001, 16'h03FF);
        step(1'b1, 16'hFFFF, 16'h0401);
        step(1'b1, 16'hFFFF, 16'h03FF);
        // R9: most negative squared
        step(1'b1, 16'h8000, 16'h8000);
        // R5: tie on 32767.5 rounds to even 32768 and must clamp
        step(1'b1, 16'd17476, 16'd3840);
        // R5: large negative clamps low
        step(1'b1, 16'h7FFF, 16'h8000);
        step(1'b1, 16'h7FFF, 16'h7FFF);
        // R11: operands without valid are ignored
        step(1'b0, 16'h8000, 16'h8000);
        step(1'b0, 16'h7FFF, 16'h8000);
        // R2: exact values
        step(1'b1, 16'h0800, 16'h0800);   // 1.0 * 1.0
        step(1'b1, 16'hF800, 16'h1000);   // -1.0 * 2.0
        step(1'b1, 16'h0000, 16'h8000);

        // R10: random back-to-back stream with occasional idle beats
        for (int i = 0; i < 3000; i++) begin
            logic v;
            logic [15:0] a, b;
            v = ($urandom % 8) != 0;
            a = 16'($urandom);
            b = 16'($urandom);
            if (($urandom % 4) == 0) a = {{5{a[15]}}, a[10:0]};
            step(v, a, b);
        end
        step(1'b0, 16'h0, 16'h0);
        step(1'b0, 16'h0, 16'h0);
        step(1'b0, 16'h0, 16'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule